// File: doc/BRIEF.md
# Four-Port Pin Controller with Peripheral Routing

This block owns the pins of four 8-bit general-purpose ports. Each port has a data latch and a direction register, and both sit on a byte-wide special-function-register bus. A direction bit of 1 turns its pin into an output that shows the latched value. A direction bit of 0 leaves the pin as an input, and reads then return the pin's synchronized level.

Port 3 also lends its pins to on-chip peripherals. Its three output-style pins (UART transmit, I2C master clock, I2C master data) carry the peripheral's signal whenever the pin is an output and that peripheral's enable is high. Its five input-style pins (UART receive, two timer inputs, two capture/compare inputs) feed the peripheral only while the pin is an input. The low half of Port 1 can drive only while an external timer clock-enable is high.

Register access takes effect in the cycle it is presented and never stalls, so the bus has no valid/ready handshake and no back-pressure. Reads are combinational on the address.

Top module: `pio_bank`

## Requirements
- R1: While reset is asserted and after it is released, every direction register and every data latch holds 0, so `pin_oe` is all zero.
- R2: Pin `8*p+b` has `pin_oe` equal to direction bit b of port p. Its `pin_out` shows data bit b, apart from the routed Port 3 pins covered by R7 and the gating in R9.
- R3: A byte write with `sfr_wr` loads the addressed register. Data latches sit at 80h, 90h, A0h and B0h for ports 0 to 3. Direction registers sit at 9Bh, 9Ch, 9Dh and 9Eh.
- R4: A plain read (`sfr_rmw`=0) of a data address returns the latch for bits whose direction is 1. For bits whose direction is 0 it returns `pin_in` as it was two rising edges earlier. A read of a direction address returns that register.
- R5: A read with `sfr_rmw`=1 of a data address returns the latch for all eight bits, whatever the pin levels.
- R6: A bit write (`sfr_bit_wr`) sets bit `sfr_bit_idx` of the addressed register to `sfr_bit_val` and leaves its other bits unchanged. If `sfr_wr` is high in the same cycle, the byte write wins.
- R7: Port 3 bit 0 shows `uart_tx` when its direction bit and `uart_en` are both 1. Bit 7 shows `i2c_scl_o` and bit 6 shows `i2c_sda_o` when their direction bit and `i2c_en` are 1. In every other case these pins show their data bit.
- R8: While the direction bit is 0, Port 3 bits 1, 2, 3, 4 and 5 drive `uart_rx`, `tmr0_in`, `cc0_in`, `cc1_in` and `tmr1_in`, each with the two-edge synchronizer delay. While the direction bit is 1, that peripheral input is held at 1.
- R9: Port 1 bits 3:0 have `pin_oe` low whenever `t2_clk_en` is 0. Port 1 bits 7:4 do not depend on `t2_clk_en`.
- R10: A read of an address outside the map returns 0, and a write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_bit_wr | input | 1 | Single-bit write strobe |
| sfr_bit_idx | input | 3 | Bit position for a bit write |
| sfr_bit_val | input | 1 | Value for a bit write |
| sfr_rmw | input | 1 | Read returns latch instead of pin level |
| sfr_rdata | output | 8 | Read data |
| t2_clk_en | input | 1 | Enables Port 1 bits 3:0 to drive |
| pin_in | input | 32 | Pin levels, bit 8*p+b for port p bit b |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| uart_en | input | 1 | UART transmit routing enable |
| uart_tx | input | 1 | UART transmit from peripheral |
| uart_rx | output | 1 | UART receive to peripheral |
| i2c_en | input | 1 | I2C master routing enable |
| i2c_scl_o | input | 1 | I2C clock from peripheral |
| i2c_sda_o | input | 1 | I2C data from peripheral |
| tmr0_in | output | 1 | Timer 0 count input |
| tmr1_in | output | 1 | Timer 1 count input |
| cc0_in | output | 1 | Capture/compare input 0 |
| cc1_in | output | 1 | Capture/compare input 1 |

## Verification
Several properties are checked on every cycle. The assertions hold the Port 1 nibble gating, the UART transmit substitution, and the receive path delayed by exactly two edges. They also check that a single-bit write changes only its target bit, that a latched read returns the byte just written, and that unmapped reads return zero. Other behaviours only show up in the bench's scenarios, which a per-cycle reference model follows. These are the mixed input/output read of a port, the I2C clock and data substitution as the enables toggle, the held-high inputs of the five capture and timer lines, and the precedence between direction and peripheral enable on each Port 3 pin.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PIO_PORTS = 4;
  localparam int PIO_W     = 8;
  localparam int PIO_IDX_W = $clog2(PIO_W);
  localparam int PIO_ALL_W = PIO_PORTS * PIO_W;

  localparam logic [7:0] PIO_DATA_BASE = 8'h80;
  localparam logic [7:0] PIO_DATA_STEP = 8'h10;
  localparam logic [7:0] PIO_CFG_BASE  = 8'h9B;

  localparam int PIO_ALT_PORT   = 3;
  localparam int PIO_GATED_PORT = 1;
  localparam int PIO_GATED_BITS = 4;

  // bit positions inside the routed port
  localparam int ALT_UTX = 0;
  localparam int ALT_URX = 1;
  localparam int ALT_T0  = 2;
  localparam int ALT_CC0 = 3;
  localparam int ALT_CC1 = 4;
  localparam int ALT_T1  = 5;
  localparam int ALT_SDA = 6;
  localparam int ALT_SCL = 7;

  typedef struct packed {
    logic                 wr;
    logic                 bit_wr;
    logic [7:0]           addr;
    logic [PIO_W-1:0]     wdata;
    logic [PIO_IDX_W-1:0] idx;
    logic                 bval;
  } pio_req_t;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pio_port_regs.sv
module pio_port_regs
  import pio_pkg::*;
#(
  parameter logic [7:0] DATA_ADDR = 8'h80,
  parameter logic [7:0] CFG_ADDR  = 8'h9B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pio_req_t         req,
  input  logic             rmw,
  input  logic [PIO_W-1:0] pin_sync,
  output logic [PIO_W-1:0] data_q,
  output logic [PIO_W-1:0] cfg_q,
  output logic [PIO_W-1:0] rd_data
);
  logic [PIO_W-1:0] data_d, cfg_d;
  logic hit_data, hit_cfg;

  assign hit_data = (req.addr == DATA_ADDR);
  assign hit_cfg  = (req.addr == CFG_ADDR);

  always_comb begin
    data_d = data_q;
    cfg_d  = cfg_q;
    if (req.wr) begin
      if (hit_data) data_d = req.wdata;
      if (hit_cfg)  cfg_d  = req.wdata;
    end else if (req.bit_wr) begin
      if (hit_data) data_d[req.idx] = req.bval;
      if (hit_cfg)  cfg_d[req.idx]  = req.bval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cfg_q  <= '0;
    end else begin
      data_q <= data_d;
      cfg_q  <= cfg_d;
    end
  end

  always_comb begin
    if (hit_data)
      rd_data = rmw ? data_q : ((data_q & cfg_q) | (pin_sync & ~cfg_q));
    else if (hit_cfg)
      rd_data = cfg_q;
    else
      rd_data = '0;
  end
endmodule

// File: rtl/pio_alt_route.sv
module pio_alt_route
  import pio_pkg::*;
(
  input  logic [PIO_W-1:0] data_q,
  input  logic [PIO_W-1:0] cfg_q,
  input  logic [PIO_W-1:0] pin_sync,
  input  logic             uart_en,
  input  logic             uart_tx,
  input  logic             i2c_en,
  input  logic             i2c_scl_o,
  input  logic             i2c_sda_o,
  output logic [PIO_W-1:0] port_out,
  output logic [PIO_W-1:0] port_oe,
  output logic             uart_rx,
  output logic             tmr0_in,
  output logic             tmr1_in,
  output logic             cc0_in,
  output logic             cc1_in
);
  always_comb begin
    port_out = data_q;
    if (cfg_q[ALT_UTX] && uart_en) port_out[ALT_UTX] = uart_tx;
    if (cfg_q[ALT_SCL] && i2c_en)  port_out[ALT_SCL] = i2c_scl_o;
    if (cfg_q[ALT_SDA] && i2c_en)  port_out[ALT_SDA] = i2c_sda_o;
  end

  assign port_oe = cfg_q;

  // inputs idle high while the pin is claimed as an output
  assign uart_rx = cfg_q[ALT_URX] | pin_sync[ALT_URX];
  assign tmr0_in = cfg_q[ALT_T0]  | pin_sync[ALT_T0];
  assign tmr1_in = cfg_q[ALT_T1]  | pin_sync[ALT_T1];
  assign cc0_in  = cfg_q[ALT_CC0] | pin_sync[ALT_CC0];
  assign cc1_in  = cfg_q[ALT_CC1] | pin_sync[ALT_CC1];
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           sfr_addr,
  input  logic                 sfr_wr,
  input  logic [PIO_W-1:0]     sfr_wdata,
  input  logic                 sfr_bit_wr,
  input  logic [PIO_IDX_W-1:0] sfr_bit_idx,
  input  logic                 sfr_bit_val,
  input  logic                 sfr_rmw,
  output logic [PIO_W-1:0]     sfr_rdata,
  input  logic                 t2_clk_en,
  input  logic [PIO_ALL_W-1:0] pin_in,
  output logic [PIO_ALL_W-1:0] pin_out,
  output logic [PIO_ALL_W-1:0] pin_oe,
  input  logic                 uart_en,
  input  logic                 uart_tx,
  output logic                 uart_rx,
  input  logic                 i2c_en,
  input  logic                 i2c_scl_o,
  input  logic                 i2c_sda_o,
  output logic                 tmr0_in,
  output logic                 tmr1_in,
  output logic                 cc0_in,
  output logic                 cc1_in
);
  localparam logic [PIO_W-1:0] GATE_MASK = PIO_W'((1 << PIO_GATED_BITS) - 1);

  pio_req_t          req;
  logic [PIO_W-1:0]  rd_vec [PIO_PORTS];

  assign req = '{wr: sfr_wr, bit_wr: sfr_bit_wr, addr: sfr_addr,
                 wdata: sfr_wdata, idx: sfr_bit_idx, bval: sfr_bit_val};

  for (genvar p = 0; p < PIO_PORTS; p++) begin : g_port
    logic [PIO_W-1:0] sync_q, data_q, cfg_q;

    pio_sync #(.W(PIO_W)) sync_i (
      .clk(clk), .rst_n(rst_n),
      .d(pin_in[p*PIO_W +: PIO_W]), .q(sync_q)
    );

    pio_port_regs #(
      .DATA_ADDR(8'(PIO_DATA_BASE + p * PIO_DATA_STEP)),
      .CFG_ADDR (8'(PIO_CFG_BASE + p))
    ) regs_i (
      .clk(clk), .rst_n(rst_n), .req(req), .rmw(sfr_rmw),
      .pin_sync(sync_q), .data_q(data_q), .cfg_q(cfg_q), .rd_data(rd_vec[p])
    );

    if (p == PIO_ALT_PORT) begin : g_alt
      pio_alt_route alt_i (
        .data_q(data_q), .cfg_q(cfg_q), .pin_sync(sync_q),
        .uart_en(uart_en), .uart_tx(uart_tx),
        .i2c_en(i2c_en), .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o),
        .port_out(pin_out[p*PIO_W +: PIO_W]),
        .port_oe(pin_oe[p*PIO_W +: PIO_W]),
        .uart_rx(uart_rx), .tmr0_in(tmr0_in), .tmr1_in(tmr1_in),
        .cc0_in(cc0_in), .cc1_in(cc1_in)
      );
    end else if (p == PIO_GATED_PORT) begin : g_gated
      assign pin_out[p*PIO_W +: PIO_W] = data_q;
      assign pin_oe[p*PIO_W +: PIO_W]  = cfg_q & (~GATE_MASK | {PIO_W{t2_clk_en}});
    end else begin : g_plain
      assign pin_out[p*PIO_W +: PIO_W] = data_q;
      assign pin_oe[p*PIO_W +: PIO_W]  = cfg_q;
    end
  end

  // at most one port decodes any address, so the merge is an OR
  always_comb begin
    sfr_rdata = '0;
    for (int p = 0; p < PIO_PORTS; p++) sfr_rdata |= rd_vec[p];
  end
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk
  import pio_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [7:0]           sfr_addr,
  input logic                 sfr_wr,
  input logic [PIO_W-1:0]     sfr_wdata,
  input logic                 sfr_bit_wr,
  input logic [PIO_IDX_W-1:0] sfr_bit_idx,
  input logic                 sfr_bit_val,
  input logic                 sfr_rmw,
  input logic [PIO_W-1:0]     sfr_rdata,
  input logic                 t2_clk_en,
  input logic [PIO_ALL_W-1:0] pin_in,
  input logic [PIO_ALL_W-1:0] pin_out,
  input logic [PIO_ALL_W-1:0] pin_oe,
  input logic                 uart_en,
  input logic                 uart_tx,
  input logic                 uart_rx
);
  logic [1:0] since_rst;
  logic       settled, mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  assign settled = (since_rst >= 2'd2);

  always_comb begin
    mapped = 1'b0;
    for (int p = 0; p < PIO_PORTS; p++) begin
      if (sfr_addr == 8'(PIO_DATA_BASE + p * PIO_DATA_STEP)) mapped = 1'b1;
      if (sfr_addr == 8'(PIO_CFG_BASE + p)) mapped = 1'b1;
    end
  end

  // R1: no pin drives while reset is held
  always @(posedge clk) begin
    if (!rst_n) assert_reset_inputs_R1: assert (pin_oe == '0);
  end

  assert_gate_low_nibble_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !t2_clk_en |-> pin_oe[11:8] == 4'h0);

  assert_uart_tx_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_en && pin_oe[24]) |-> pin_out[24] == uart_tx);

  assert_rx_two_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !pin_oe[25]) |-> uart_rx == $past(pin_in[25], 2));

  assert_bit_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_bit_wr && !sfr_wr && sfr_addr == 8'hA0)
    |=> ((pin_out[23:16] >> $past(sfr_bit_idx)) & 8'd1) == {7'd0, $past(sfr_bit_val)});

  assert_bit_isolate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_bit_wr && !sfr_wr && sfr_addr == 8'hA0)
    |=> ((pin_out[23:16] ^ $past(pin_out[23:16])) & ~(8'd1 << $past(sfr_bit_idx))) == 8'd0);

  assert_latch_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == 8'h80) |=> ((sfr_rmw && sfr_addr == 8'h80) -> sfr_rdata == $past(sfr_wdata)));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> sfr_rdata == '0);
endmodule

bind pio_bank pio_bank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
  .sfr_wdata(sfr_wdata), .sfr_bit_wr(sfr_bit_wr), .sfr_bit_idx(sfr_bit_idx),
  .sfr_bit_val(sfr_bit_val), .sfr_rmw(sfr_rmw), .sfr_rdata(sfr_rdata),
  .t2_clk_en(t2_clk_en), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
  .uart_en(uart_en), .uart_tx(uart_tx), .uart_rx(uart_rx)
);

// File: tb/pio_bank_tb_top.sv
module pio_bank_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic        sfr_wr = 0, sfr_bit_wr = 0, sfr_bit_val = 0, sfr_rmw = 0;
  logic [2:0]  sfr_bit_idx = 0;
  logic        t2_clk_en = 0;
  logic [31:0] pin_in = 0, pin_out, pin_oe;
  logic        uart_en = 0, uart_tx = 0, uart_rx;
  logic        i2c_en = 0, i2c_scl_o = 0, i2c_sda_o = 0;
  logic        tmr0_in, tmr1_in, cc0_in, cc1_in;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pio_bank dut_i (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_bit_wr(sfr_bit_wr), .sfr_bit_idx(sfr_bit_idx),
    .sfr_bit_val(sfr_bit_val), .sfr_rmw(sfr_rmw), .sfr_rdata(sfr_rdata),
    .t2_clk_en(t2_clk_en), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .uart_en(uart_en), .uart_tx(uart_tx), .uart_rx(uart_rx),
    .i2c_en(i2c_en), .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o),
    .tmr0_in(tmr0_in), .tmr1_in(tmr1_in), .cc0_in(cc0_in), .cc1_in(cc1_in)
  );

  // behavioural reference
  logic [7:0]  m_data [4];
  logic [7:0]  m_cfg  [4];
  logic [31:0] m_s1, m_s2;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_data[i]) begin m_data[i] = 0; m_cfg[i] = 0; end
      m_s1 = 0; m_s2 = 0;
    end else begin
      m_s2 = m_s1;
      m_s1 = pin_in;
      for (int p = 0; p < 4; p++) begin
        if (sfr_wr) begin
          if (sfr_addr == 8'h80 + 8'(16 * p)) m_data[p] = sfr_wdata;
          if (sfr_addr == 8'h9B + 8'(p))      m_cfg[p]  = sfr_wdata;
        end else if (sfr_bit_wr) begin
          if (sfr_addr == 8'h80 + 8'(16 * p)) m_data[p][sfr_bit_idx] = sfr_bit_val;
          if (sfr_addr == 8'h9B + 8'(p))      m_cfg[p][sfr_bit_idx]  = sfr_bit_val;
        end
      end
    end
  end

  function automatic logic [31:0] exp_oe();
    logic [31:0] v = {m_cfg[3], m_cfg[2], m_cfg[1], m_cfg[0]};
    if (!t2_clk_en) v[11:8] = 0;
    return v;
  endfunction

  function automatic logic [31:0] exp_out();
    logic [31:0] v = {m_data[3], m_data[2], m_data[1], m_data[0]};
    if (m_cfg[3][0] && uart_en) v[24] = uart_tx;
    if (m_cfg[3][7] && i2c_en)  v[31] = i2c_scl_o;
    if (m_cfg[3][6] && i2c_en)  v[30] = i2c_sda_o;
    return v;
  endfunction

  function automatic logic [7:0] exp_rd();
    for (int p = 0; p < 4; p++) begin
      if (sfr_addr == 8'h80 + 8'(16 * p)) begin
        if (sfr_rmw) return m_data[p];
        for (int b = 0; b < 8; b++) if (!m_cfg[p][b]) exp_rd[b] = m_s2[8*p+b]; else exp_rd[b] = m_data[p][b];
        return exp_rd;
      end
      if (sfr_addr == 8'h9B + 8'(p)) return m_cfg[p];
    end
    return 8'h00;
  endfunction

  function automatic logic [4:0] exp_periph();
    logic [4:0] v;
    for (int b = 1; b <= 5; b++) v[b-1] = m_cfg[3][b] ? 1'b1 : m_s2[24+b];
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R2 pin_oe", pin_oe, exp_oe());
      chk("R7 pin_out", pin_out, exp_out());
      chk("R4 sfr_rdata", {24'd0, sfr_rdata}, {24'd0, exp_rd()});
      chk("R8 periph inputs", {27'd0, tmr1_in, cc1_in, cc0_in, tmr0_in, uart_rx},
          {27'd0, exp_periph()});
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); sfr_addr = a; sfr_wdata = d; sfr_wr = 1;
    @(negedge clk); sfr_wr = 0;
  endtask

  task automatic bwr(logic [7:0] a, logic [2:0] i, logic v);
    @(negedge clk); sfr_addr = a; sfr_bit_idx = i; sfr_bit_val = v; sfr_bit_wr = 1;
    @(negedge clk); sfr_bit_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, logic r, output logic [7:0] q);
    sfr_addr = a; sfr_rmw = r; #1; q = sfr_rdata;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] q;
    tick(3);
    chk("R1 oe in reset", pin_oe, 0);
    rst_n = 1;
    tick(1);
    chk("R1 oe after reset", pin_oe, 0);
    rd(8'h80, 1, q); chk("R1 latch after reset", q, 8'h00);

    // R2, R3: full output port
    wr(8'h9B, 8'hFF); wr(8'h80, 8'hA5);
    chk("R2 p0 out", pin_out[7:0], 8'hA5);
    chk("R2 p0 oe", pin_oe[7:0], 8'hFF);
    rd(8'h9B, 0, q); chk("R3 cfg read", q, 8'hFF);

    // R4, R5: mixed direction on port 2
    wr(8'h9D, 8'h0F); wr(8'hA0, 8'h81);
    pin_in[23:16] = 8'h3C;
    tick(3);
    rd(8'hA0, 0, q); chk("R4 mixed read", q, 8'h31);
    rd(8'hA0, 1, q); chk("R5 latch read", q, 8'h81);

    // R6: single-bit writes
    bwr(8'hA0, 3'd6, 1'b1);
    rd(8'hA0, 1, q); chk("R6 bit set", q, 8'hC1);
    bwr(8'hA0, 3'd0, 1'b0);
    rd(8'hA0, 1, q); chk("R6 bit clear", q, 8'hC0);
    @(negedge clk); sfr_addr = 8'hA0; sfr_wdata = 8'h5A; sfr_wr = 1;
    sfr_bit_wr = 1; sfr_bit_idx = 3'd0; sfr_bit_val = 1'b1;
    @(negedge clk); sfr_wr = 0; sfr_bit_wr = 0;
    rd(8'hA0, 1, q); chk("R6 byte write wins", q, 8'h5A);

    // R7: peripheral outputs on port 3
    wr(8'h9E, 8'hC1); wr(8'hB0, 8'hFF);
    uart_en = 1; uart_tx = 0; #1;
    chk("R7 uart tx routed", pin_out[24], 0);
    chk("R7 i2c disabled", pin_out[31:30], 2'b11);
    i2c_en = 1; i2c_scl_o = 0; i2c_sda_o = 1; #1;
    chk("R7 i2c routed", pin_out[31:30], 2'b01);
    uart_en = 0; #1;
    chk("R7 uart disabled", pin_out[24], 1);

    // R8: peripheral inputs on port 3
    @(negedge clk); pin_in[29:25] = 5'b10110;
    tick(3);
    chk("R8 inputs follow pins", {tmr1_in, cc1_in, cc0_in, tmr0_in, uart_rx}, 5'b10110);
    wr(8'h9E, 8'hFF);
    chk("R8 inputs held high", {tmr1_in, cc1_in, cc0_in, tmr0_in, uart_rx}, 5'b11111);

    // R9: gated low nibble of port 1
    wr(8'h9C, 8'hFF);
    chk("R9 gated off", pin_oe[15:8], 8'hF0);
    t2_clk_en = 1; #1;
    chk("R9 gated on", pin_oe[15:8], 8'hFF);

    // R10: unmapped address
    wr(8'h55, 8'hFF);
    rd(8'h55, 0, q); chk("R10 unmapped read", q, 8'h00);
    rd(8'h80, 1, q); chk("R10 no side effect", q, 8'hA5);

    tick(4);
    finish_run();
  end
endmodule